// File: doc/BRIEF.md
# Scheduled Eight-Operand Tree Adder

This unit adds a group of unsigned operand words. It does not run one long accumulate chain. It pairs the operands up in a balanced binary tree. At each tree level the independent pair additions are spread over a fixed number of two-input adder lanes, set by a parameter. A level with more pairs than lanes takes several cycles. Each cycle issues as many pair additions as there are free lanes.

A single-cycle start strobe captures all operand words at once. When the final sum has been formed, a one-cycle done pulse appears. The widened sum and the number of cycles the reduction took are held on the outputs until the next result replaces them. With the default eight operands, four lanes finish in three cycles, two lanes in four and one lane in seven. A serial chain always needs seven additions.

Top module: `tsum_top`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0, `sum_out` is 0, `cycles` is 0 and the unit is idle.
- R2: A `start` pulse while idle captures all operands, with operand i taken from `ops_in[i*OPW +: OPW]`. Later changes on `ops_in` do not affect that reduction.
- R3: `sum_out` is OPW + log2(N_OPS) bits wide and equals the exact unsigned sum of the captured operands, including the case where every operand is at its maximum value.
- R4: `done` is high for exactly one cycle. It rises S clock edges after the edge that accepted `start`, where S is the step count of R5.
- R5: `cycles` reports S. S is the sum over tree levels of ceil(pairs at that level / N_ADD): 3 for N_ADD=4, 4 for N_ADD=2, 7 for N_ADD=1 with eight operands.
- R6: For N_ADD of 2 or more, S is strictly below the 7 steps of a serial chain over eight operands. For N_ADD=1, S equals 7.
- R7: A `start` pulse that arrives while a reduction is in progress, including in the cycle of its last step, is ignored. It changes neither the result nor the timing.
- R8: `sum_out` and `cycles` hold their values between done pulses.
- R9: A `start` in the cycle right after the last step's edge, while `done` is high, is accepted. This allows back-to-back reductions every S+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin a reduction when idle |
| ops_in | input | N_OPS*OPW | Packed operand words, operand i at bits [i*OPW +: OPW] |
| sum_out | output | OPW+log2(N_OPS) | Registered sum of the last completed reduction |
| done | output | 1 | One-cycle pulse when `sum_out` is updated |
| cycles | output | log2(N_OPS)+1 | Step count used by the last reduction |

## Verification
A wrong entry in the partial-sum slots, such as a lane writing the wrong slot or reading a stale partner, reaches the ports only at the next done pulse. There it appears as a wrong `sum_out`, at most S cycles after the fault. A wrong level or pair counter instead moves `done` off its expected edge, or makes `cycles` disagree with the formula. The cycle-accurate reference catches this on the very edge where the pulse was due. Three instances with one, two and four lanes run the same stimulus, so every schedule variant is compared cycle by cycle.

// File: rtl/tsum_pkg.sv
package tsum_pkg;
  // Steps needed to reduce n_ops words with n_add adder lanes per cycle
  function automatic int steps_for(input int n_ops, input int n_add);
    int s;
    s = 0;
    for (int p = n_ops / 2; p >= 1; p = p / 2) begin
      s += (p + n_add - 1) / n_add;
    end
    return s;
  endfunction
endpackage

// File: rtl/tsum_lane.sv
module tsum_lane #(
  parameter int RW = 19
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] b,
  output logic [RW-1:0] s
);
  assign s = a + b;
endmodule

// File: rtl/tsum_sched.sv
module tsum_sched #(
  parameter int N_OPS = 8,
  parameter int N_ADD = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  output logic                        busy,
  output logic [$clog2($clog2(N_OPS)+1)-1:0] lvl,
  output logic [$clog2(N_OPS)-1:0]    pidx,
  output logic                        last,
  output logic [$clog2(N_OPS):0]      step_cnt
);
  localparam int LVLS = $clog2(N_OPS);
  localparam int LW   = $clog2(LVLS + 1);
  localparam int IW   = $clog2(N_OPS);
  localparam int CW   = $clog2(N_OPS) + 1;

  logic level_end;
  int   pairs_now;

  always_comb begin
    pairs_now = N_OPS >> (int'(lvl) + 1);
    level_end = (int'(pidx) + N_ADD) >= pairs_now;
    last      = busy && level_end && (int'(lvl) == LVLS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      lvl      <= '0;
      pidx     <= '0;
      step_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        lvl      <= '0;
        pidx     <= '0;
        step_cnt <= '0;
      end
    end else begin
      step_cnt <= step_cnt + CW'(1);
      if (level_end) begin
        pidx <= '0;
        if (int'(lvl) == LVLS - 1) busy <= 1'b0;
        else                       lvl  <= lvl + LW'(1);
      end else begin
        pidx <= pidx + IW'(N_ADD);
      end
    end
  end
endmodule

// File: rtl/tsum_top.sv
module tsum_top #(
  parameter int OPW   = 16,
  parameter int N_OPS = 8,
  parameter int N_ADD = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [N_OPS*OPW-1:0]                ops_in,
  output logic [OPW+$clog2(N_OPS)-1:0]        sum_out,
  output logic                                done,
  output logic [$clog2(N_OPS):0]              cycles
);
  localparam int RW   = OPW + $clog2(N_OPS);
  localparam int LVLS = $clog2(N_OPS);
  localparam int LW   = $clog2(LVLS + 1);
  localparam int IW   = $clog2(N_OPS);
  localparam int CW   = $clog2(N_OPS) + 1;

  logic          busy, last;
  logic [LW-1:0] lvl;
  logic [IW-1:0] pidx;
  logic [CW-1:0] step_cnt;

  logic [RW-1:0] slot_q [N_OPS];
  logic [RW-1:0] lane_s [N_ADD];
  logic [IW-1:0] lane_a_idx [N_ADD];
  logic [IW-1:0] lane_b_idx [N_ADD];
  logic          lane_v [N_ADD];

  tsum_sched #(.N_OPS(N_OPS), .N_ADD(N_ADD)) u_sched (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .lvl(lvl),
    .pidx(pidx), .last(last), .step_cnt(step_cnt)
  );

  // Pair k at level L joins slots k*2^(L+1) and k*2^(L+1)+2^L, result in place
  always_comb begin
    for (int j = 0; j < N_ADD; j++) begin
      int k;
      int base;
      k             = int'(pidx) + j;
      base          = k << (int'(lvl) + 1);
      lane_v[j]     = busy && (k < (N_OPS >> (int'(lvl) + 1)));
      lane_a_idx[j] = IW'(base);
      lane_b_idx[j] = IW'(base + (1 << int'(lvl)));
    end
  end

  for (genvar j = 0; j < N_ADD; j++) begin : g_lane
    tsum_lane #(.RW(RW)) u_lane (
      .a(slot_q[lane_a_idx[j]]),
      .b(slot_q[lane_b_idx[j]]),
      .s(lane_s[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_OPS; i++) slot_q[i] <= '0;
      sum_out <= '0;
      done    <= 1'b0;
      cycles  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        for (int i = 0; i < N_OPS; i++) slot_q[i] <= RW'(ops_in[i*OPW +: OPW]);
      end else if (busy) begin
        for (int j = 0; j < N_ADD; j++) begin
          if (lane_v[j]) slot_q[lane_a_idx[j]] <= lane_s[j];
        end
        if (last) begin
          sum_out <= lane_s[0];
          done    <= 1'b1;
          cycles  <= step_cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tsum_chk.sv
module tsum_chk #(
  parameter int OPW   = 16,
  parameter int N_OPS = 8,
  parameter int N_ADD = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic [OPW+$clog2(N_OPS)-1:0] sum_out,
  input logic [$clog2(N_OPS):0]       cycles
);
  localparam int S = tsum_pkg::steps_for(N_OPS, N_ADD);

  int run_cnt;
  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= 0;
    else if (start && !busy) run_cnt <= 0;
    else if (busy)          run_cnt <= run_cnt + 1;
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_latency_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == S));
  p_count_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(cycles) == run_cnt));
  p_below_serial_r6: assert property (@(posedge clk) disable iff (rst)
    (done && N_ADD > 1) |-> (int'(cycles) < N_OPS - 1));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(sum_out) && $stable(cycles)));
  p_busy_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind tsum_top tsum_chk #(.OPW(OPW), .N_OPS(N_OPS), .N_ADD(N_ADD)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .sum_out(sum_out), .cycles(cycles)
);

// File: tb/tsum_top_tb.sv
`timescale 1ns/1ps
module tsum_top_tb;
  localparam int OPW = 16;
  localparam int NO  = 8;
  localparam int RW  = OPW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NO*OPW-1:0] ops = '0;
  logic [RW-1:0] sum_w [3];
  logic          done_w [3];
  logic [3:0]    cyc_w [3];

  int checks = 0;
  int fails  = 0;
  int wd     = 0;
  string tag = "R3";

  always #2 clk = ~clk;

  tsum_top #(.OPW(OPW), .N_OPS(NO), .N_ADD(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .ops_in(ops),
    .sum_out(sum_w[0]), .done(done_w[0]), .cycles(cyc_w[0]));
  tsum_top #(.OPW(OPW), .N_OPS(NO), .N_ADD(2)) u_dut2 (
    .clk(clk), .rst(rst), .start(start), .ops_in(ops),
    .sum_out(sum_w[1]), .done(done_w[1]), .cycles(cyc_w[1]));
  tsum_top #(.OPW(OPW), .N_OPS(NO), .N_ADD(1)) u_dut1 (
    .clk(clk), .rst(rst), .start(start), .ops_in(ops),
    .sum_out(sum_w[2]), .done(done_w[2]), .cycles(cyc_w[2]));

  // Reference model: one entry per lane count 4, 2, 1
  int steps_ref [3] = '{3, 4, 7};
  bit      m_busy [3];
  int      m_left [3];
  longint  m_pend [3];
  bit      m_done [3];
  longint  m_sum  [3];
  int      m_cyc  [3];

  function automatic longint add_all(input logic [NO*OPW-1:0] v);
    longint t = 0;
    for (int i = 0; i < NO; i++) t += longint'(v[i*OPW +: OPW]);
    return t;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (rst) begin
        m_busy[k] <= 1'b0; m_left[k] <= 0; m_pend[k] <= 0;
        m_done[k] <= 1'b0; m_sum[k] <= 0; m_cyc[k] <= 0;
      end else begin
        m_done[k] <= 1'b0;
        if (m_busy[k]) begin
          m_left[k] <= m_left[k] - 1;
          if (m_left[k] == 1) begin
            m_busy[k] <= 1'b0;
            m_done[k] <= 1'b1;
            m_sum[k]  <= m_pend[k];
            m_cyc[k]  <= steps_ref[k];
          end
        end else if (start) begin
          m_busy[k] <= 1'b1;
          m_left[k] <= steps_ref[k];
          m_pend[k] <= add_all(ops);
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 3; k++) begin
        checks++;
        if (done_w[k] !== m_done[k]) begin
          fails++;
          $display("FAIL R4 (%s) lanes#%0d done actual %0b expected %0b", tag, k, done_w[k], m_done[k]);
        end else if (longint'(sum_w[k]) != m_sum[k]) begin
          fails++;
          $display("FAIL R3 (%s) lanes#%0d sum actual %0d expected %0d", tag, k, sum_w[k], m_sum[k]);
        end else if (int'(cyc_w[k]) != m_cyc[k]) begin
          fails++;
          $display("FAIL R5 (%s) lanes#%0d cycles actual %0d expected %0d", tag, k, cyc_w[k], m_cyc[k]);
        end
        if (done_w[k]) begin
          checks++;
          if ((k < 2 && cyc_w[k] >= 7) || (k == 2 && cyc_w[k] != 7)) begin
            fails++;
            $display("FAIL R6 lanes#%0d cycles actual %0d expected %s", k, cyc_w[k], (k < 2) ? "<7" : "7");
          end
        end
      end
    end
  end

  task automatic issue(input logic [NO*OPW-1:0] v, input int gap);
    @(negedge clk);
    ops = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NO*OPW-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (done_w[k] !== 1'b0 || sum_w[k] !== '0 || cyc_w[k] !== '0) begin
        fails++;
        $display("FAIL R1 lanes#%0d actual done=%0b sum=%0d cyc=%0d expected 0/0/0", k, done_w[k], sum_w[k], cyc_w[k]);
      end
    end
    rst = 1'b0;
    @(negedge clk);

    tag = "R2";
    for (int i = 0; i < NO; i++) v[i*OPW +: OPW] = OPW'(i + 1);
    issue(v, 9);
    tag = "R3";
    issue('1, 9);
    issue('0, 9);
    for (int i = 0; i < NO; i++) v[i*OPW +: OPW] = (i == 7) ? 16'h8000 : 16'h0000;
    issue(v, 9);
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < NO; i++) v[i*OPW +: OPW] = OPW'($urandom);
      issue(v, 9);
    end

    // R7: extra starts with new operands while busy
    tag = "R7";
    for (int i = 0; i < NO; i++) v[i*OPW +: OPW] = OPW'(1000 * (i + 1));
    issue(v, 0);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      ops = {NO{16'h00F0 + 16'(c)}}; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);

    // R9 / R2: start held high, operands changing every cycle
    tag = "R9";
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      start = 1'b1;
      for (int i = 0; i < NO; i++) ops[i*OPW +: OPW] = OPW'($urandom);
    end
    @(negedge clk);
    start = 1'b0;
    tag = "R8";
    repeat (12) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule